// File: doc/BRIEF.md
# Sector Bit-Error Corrector

This block takes the result of an eight-error BCH decode for one 512-byte sector and applies it to the sector, which sits in a byte-wide local buffer. The buffer also holds the 13 stored check bytes. A single start pulse hands over four 32-bit words. The first three words and one byte of the fourth carry eight packed 13-bit error locations. A 4-bit field of the fourth word gives the number of errors found. The block then takes one of three paths.

The first path is to do nothing, when no errors are reported. The second is to flip the reported bits, when at most eight errors are reported. The third handles a decode that reports too many errors. In that case the block checks whether the sector is simply an erased page, meaning almost every bit is still one. If it is, the block rewrites the data with all ones. If it is not, it marks the sector uncorrectable.

The buffer is reached through one combinational-read, clocked-write byte port, so every step takes one byte per cycle. The block reports its result on `fixCount` and `fail`, which are valid while `done` pulses.

Top module: `bch_sector_fixer`

## Requirements
- R1: The error count is taken from bits 13:10 of `statusWord`. No other bits of that word affect it. A count of 0 leaves the buffer untouched and reports `fixCount`=0 and `fail`=0.
- R2: Location k (k = 0..7) is bits 13k+12 down to 13k of a 104-bit vector. That vector is built as {statusWord[23:16], errWord3, errWord2, errWord1}, with `errWord1` in the low bits. So location 2 straddles errWord1/errWord2, location 4 straddles errWord2/errWord3, and location 7 straddles errWord3/statusWord.
- R3: Each location has its bits 0 and 1 inverted before use. For example, a raw value of 0 addresses byte 0, bit 3.
- R4: An adjusted location below 4096 flips bit (loc mod 8) of data byte loc/8. A location of 4096 or more changes nothing. `fixCount` equals the number of flips performed.
- R5: With a count N from 1 to 8, only locations 0..N-1 are applied. Locations at N and above have no effect.
- R6: A count of 9..15 starts an erased check. This check counts zero bits separately in the check bytes (buffer addresses 512..524) and in the data bytes (addresses 0..511). If the two totals together are 8 or less, data bytes 0..511 become 0xFF, the check bytes are left as they are, and the result is `fixCount`=0 and `fail`=0.
- R7: If the erased check finds more than 8 zero bits in total, `fail` is 1, `fixCount` is 0 and the buffer is unchanged.
- R8: `busy` rises the cycle after an accepted start and stays high through the single-cycle `done` pulse. A start pulse while `busy` is high is ignored.
- R9: The block writes only to data addresses (below 512), and only while `busy` is high.
- R10: After reset, `busy`, `done`, `memWe`, `fixCount` and `fail` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a job; the words are captured in the same cycle |
| errWord1 | input | 32 | Location vector bits 31:0 |
| errWord2 | input | 32 | Location vector bits 63:32 |
| errWord3 | input | 32 | Location vector bits 95:64 |
| statusWord | input | 32 | Error count in 13:10, location vector bits 103:96 in 23:16 |
| memAddr | output | 10 | Buffer byte address (data 0..511, check bytes 512..524) |
| memWe | output | 1 | Write `memWdata` at `memAddr` on this clock edge |
| memWdata | output | 8 | Byte to write |
| memRdata | input | 8 | Byte at `memAddr`, combinational |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| fixCount | output | 4 | Bits flipped by the job |
| fail | output | 1 | Sector uncorrectable |

## Verification
The hardest case to reach is the erased-page decision right at its edge. Here the zero bits are split between the check bytes and the data bytes, so that neither part passes eight on its own while their sum lands on eight or nine. Reaching it also means covering the early exit taken when one part alone passes eight. The stimulus reloads the buffer with an all-ones image and clears a chosen number of bits in each region, sweeping both numbers from 0 to 10. This covers every combination on both sides of the limit, with the error count also varied across 9..15. The bit-flip path is swept over all 8192 raw values of one location and over every slot position, so a wrong slice or a wrong inversion shows up as a buffer mismatch.

// File: rtl/bch_fix_pkg.sv
package bch_fix_pkg;

  localparam int WORD_W       = 32;
  localparam int PACK_W       = 104;
  localparam int CNT_FIELD_LO = 10;
  localparam int CNT_FIELD_W  = 4;
  localparam int TOP_FIELD_LO = 16;
  localparam int TOP_FIELD_W  = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_FIX,
    ST_SCAN_ECC,
    ST_SCAN_DATA,
    ST_CHECK,
    ST_FILL,
    ST_DONE
  } fixState_t;

  typedef struct packed {
    logic load;
    logic fixStep;
    logic cntEcc;
    logic cntData;
    logic fillStep;
    logic setFail;
  } fixStrobe_t;

endpackage

// File: rtl/bch_fix_ctrl.sv
module bch_fix_ctrl
  import bch_fix_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int ECC_BYTES    = 13,
  parameter int MAX_ERR      = 8,
  parameter int ADDR_W       = 10
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [CNT_FIELD_W-1:0] errCnt,
  input  logic                   overLimit,
  input  logic                   sumOk,
  output fixStrobe_t             strobes,
  output logic [ADDR_W-1:0]      ptr,
  output logic                   busy,
  output logic                   done
);

  localparam logic [ADDR_W-1:0] LAST_ECC  = ADDR_W'(ECC_BYTES - 1);
  localparam logic [ADDR_W-1:0] LAST_DATA = ADDR_W'(SECTOR_BYTES - 1);

  fixState_t state, nextState;
  logic [ADDR_W-1:0] nextPtr;
  logic [ADDR_W-1:0] lastSlot;

  assign lastSlot = ADDR_W'(errCnt) - ADDR_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      ptr   <= '0;
    end else begin
      state <= nextState;
      ptr   <= nextPtr;
    end
  end

  always_comb begin
    strobes   = '0;
    nextState = state;
    nextPtr   = ptr;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobes.load = 1'b1;
          nextState    = ST_DECIDE;
          nextPtr      = '0;
        end
      end
      ST_DECIDE: begin
        nextPtr = '0;
        if (errCnt == '0)                 nextState = ST_DONE;
        else if (int'(errCnt) <= MAX_ERR) nextState = ST_FIX;
        else                              nextState = ST_SCAN_ECC;
      end
      ST_FIX: begin
        strobes.fixStep = 1'b1;
        if (ptr == lastSlot) nextState = ST_DONE;
        else                 nextPtr   = ptr + 1'b1;
      end
      ST_SCAN_ECC: begin
        if (overLimit) begin
          strobes.setFail = 1'b1;
          nextState       = ST_DONE;
        end else begin
          strobes.cntEcc = 1'b1;
          if (ptr == LAST_ECC) begin
            nextState = ST_SCAN_DATA;
            nextPtr   = '0;
          end else begin
            nextPtr = ptr + 1'b1;
          end
        end
      end
      ST_SCAN_DATA: begin
        if (overLimit) begin
          strobes.setFail = 1'b1;
          nextState       = ST_DONE;
        end else begin
          strobes.cntData = 1'b1;
          if (ptr == LAST_DATA) nextState = ST_CHECK;
          else                  nextPtr   = ptr + 1'b1;
        end
      end
      ST_CHECK: begin
        nextPtr = '0;
        if (sumOk) begin
          nextState = ST_FILL;
        end else begin
          strobes.setFail = 1'b1;
          nextState       = ST_DONE;
        end
      end
      ST_FILL: begin
        strobes.fillStep = 1'b1;
        if (ptr == LAST_DATA) nextState = ST_DONE;
        else                  nextPtr   = ptr + 1'b1;
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

endmodule

// File: rtl/bch_fix_datapath.sv
module bch_fix_datapath
  import bch_fix_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int MAX_ERR      = 8,
  parameter int IDX_W        = 13,
  parameter int ADDR_W       = 10,
  parameter int CNT_W        = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  fixStrobe_t             strobes,
  input  logic [ADDR_W-1:0]      ptr,
  input  logic [WORD_W-1:0]      errWord1,
  input  logic [WORD_W-1:0]      errWord2,
  input  logic [WORD_W-1:0]      errWord3,
  input  logic [WORD_W-1:0]      statusWord,
  input  logic [7:0]             memRdata,
  output logic [ADDR_W-1:0]      memAddr,
  output logic                   memWe,
  output logic [7:0]             memWdata,
  output logic [CNT_FIELD_W-1:0] errCnt,
  output logic                   overLimit,
  output logic                   sumOk,
  output logic [CNT_W-1:0]       fixCount,
  output logic                   fail
);

  localparam int SECTOR_BITS = SECTOR_BYTES * 8;
  localparam int SLOT_W      = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1;
  localparam int ZW          = $clog2(2 * MAX_ERR + 2) + 1;
  localparam logic [ZW-1:0] ZSAT  = ZW'(MAX_ERR + 1);
  localparam logic [ZW-1:0] ZLIM  = ZW'(MAX_ERR);

  logic [PACK_W-1:0] locVec;
  logic [IDX_W-1:0]  slotIdx [MAX_ERR];
  logic [IDX_W-1:0]  adjIdx;
  logic              inRange;
  logic [7:0]        bitMask;
  logic [3:0]        zeroHere;
  logic [ZW-1:0]     eccZeros, dataZeros, eccSum, dataSum, eccNext, dataNext;
  logic              unusedStatus;

  assign unusedStatus = ^{statusWord[31:24], statusWord[15:14], statusWord[9:0]};

  generate
    for (genvar g = 0; g < MAX_ERR; g++) begin : g_slot
      assign slotIdx[g] = locVec[g*IDX_W +: IDX_W];
    end
  endgenerate

  assign adjIdx  = slotIdx[ptr[SLOT_W-1:0]] ^ IDX_W'(3);
  assign inRange = int'(adjIdx) < SECTOR_BITS;
  assign bitMask = 8'(1) << adjIdx[2:0];

  always_comb begin
    memAddr  = ptr;
    memWe    = 1'b0;
    memWdata = memRdata;
    if (strobes.fixStep) begin
      memAddr  = ADDR_W'(adjIdx >> 3);
      memWe    = inRange;
      memWdata = memRdata ^ bitMask;
    end else if (strobes.cntEcc) begin
      memAddr = ADDR_W'(SECTOR_BYTES) + ptr;
    end else if (strobes.fillStep) begin
      memWe    = 1'b1;
      memWdata = 8'hFF;
    end
  end

  assign zeroHere = 4'($countones(~memRdata));
  assign eccSum   = eccZeros + ZW'(zeroHere);
  assign dataSum  = dataZeros + ZW'(zeroHere);
  assign eccNext  = (eccSum > ZSAT) ? ZSAT : eccSum;
  assign dataNext = (dataSum > ZSAT) ? ZSAT : dataSum;

  assign overLimit = (eccZeros > ZLIM) || (dataZeros > ZLIM);
  assign sumOk     = ({1'b0, eccZeros} + {1'b0, dataZeros}) <= {1'b0, ZLIM};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locVec    <= '0;
      errCnt    <= '0;
      eccZeros  <= '0;
      dataZeros <= '0;
      fixCount  <= '0;
      fail      <= 1'b0;
    end else if (strobes.load) begin
      locVec    <= {statusWord[TOP_FIELD_LO +: TOP_FIELD_W], errWord3, errWord2, errWord1};
      errCnt    <= statusWord[CNT_FIELD_LO +: CNT_FIELD_W];
      eccZeros  <= '0;
      dataZeros <= '0;
      fixCount  <= '0;
      fail      <= 1'b0;
    end else begin
      if (strobes.fixStep && inRange) fixCount <= fixCount + 1'b1;
      if (strobes.cntEcc)             eccZeros <= eccNext;
      if (strobes.cntData)            dataZeros <= dataNext;
      if (strobes.setFail)            fail <= 1'b1;
    end
  end

endmodule

// File: rtl/bch_sector_fixer.sv
module bch_sector_fixer
  import bch_fix_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int ECC_BYTES    = 13,
  parameter int MAX_ERR      = 8,
  parameter int IDX_W        = 13,
  parameter int ADDR_W       = $clog2(SECTOR_BYTES + ECC_BYTES),
  parameter int CNT_W        = $clog2(MAX_ERR + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [31:0]       errWord1,
  input  logic [31:0]       errWord2,
  input  logic [31:0]       errWord3,
  input  logic [31:0]       statusWord,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  fixCount,
  output logic              fail
);

  fixStrobe_t               strobes;
  logic [ADDR_W-1:0]        ptr;
  logic [CNT_FIELD_W-1:0]   errCnt;
  logic                     overLimit;
  logic                     sumOk;

  bch_fix_ctrl #(
    .SECTOR_BYTES(SECTOR_BYTES),
    .ECC_BYTES   (ECC_BYTES),
    .MAX_ERR     (MAX_ERR),
    .ADDR_W      (ADDR_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .errCnt   (errCnt),
    .overLimit(overLimit),
    .sumOk    (sumOk),
    .strobes  (strobes),
    .ptr      (ptr),
    .busy     (busy),
    .done     (done)
  );

  bch_fix_datapath #(
    .SECTOR_BYTES(SECTOR_BYTES),
    .MAX_ERR     (MAX_ERR),
    .IDX_W       (IDX_W),
    .ADDR_W      (ADDR_W),
    .CNT_W       (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .ptr       (ptr),
    .errWord1  (errWord1),
    .errWord2  (errWord2),
    .errWord3  (errWord3),
    .statusWord(statusWord),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWe     (memWe),
    .memWdata  (memWdata),
    .errCnt    (errCnt),
    .overLimit (overLimit),
    .sumOk     (sumOk),
    .fixCount  (fixCount),
    .fail      (fail)
  );

endmodule

// File: rtl/bch_sector_fixer_chk.sv
module bch_sector_fixer_chk #(
  parameter int SECTOR_BYTES = 512,
  parameter int MAX_ERR      = 8,
  parameter int ADDR_W       = 10,
  parameter int CNT_W        = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [CNT_W-1:0]  fixCount,
  input logic              fail
);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_in_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  assert_start_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  assert_write_data_only_R9: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (int'(memAddr) < SECTOR_BYTES));

  assert_idle_no_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memWe);

  assert_fail_no_fix_R7: assert property (@(posedge clk) disable iff (!rstN)
    fail |-> (fixCount == '0));

  assert_fix_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    int'(fixCount) <= MAX_ERR);

  assert_result_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(fixCount) && $stable(fail)));

endmodule

bind bch_sector_fixer bch_sector_fixer_chk #(
  .SECTOR_BYTES(SECTOR_BYTES),
  .MAX_ERR     (MAX_ERR),
  .ADDR_W      (ADDR_W),
  .CNT_W       (CNT_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .memWe   (memWe),
  .memAddr (memAddr),
  .fixCount(fixCount),
  .fail    (fail)
);

// File: tb/bch_sector_fixer_bench.sv
module bch_sector_fixer_bench;

  localparam int DATA_N = 512;
  localparam int ECC_N  = 13;
  localparam int MEM_N  = DATA_N + ECC_N;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] errWord1 = '0, errWord2 = '0, errWord3 = '0, statusWord = '0;
  logic [9:0]  memAddr;
  logic        memWe;
  logic [7:0]  memWdata;
  logic [7:0]  memRdata;
  logic        busy, done, fail;
  logic [3:0]  fixCount;

  logic [7:0]  mem      [MEM_N];
  logic [7:0]  stageMem [MEM_N];
  logic [7:0]  expMem   [MEM_N];
  logic        loadPulse = 1'b0;
  logic [12:0] slots    [8];
  int          expCnt;
  bit          expFail;
  int          checks = 0, failures = 0, cycles = 0;
  int          badWrites = 0;

  always #4 clk = ~clk;

  bch_sector_fixer u_bch_sector_fixer (
    .clk(clk), .rstN(rstN), .start(start),
    .errWord1(errWord1), .errWord2(errWord2), .errWord3(errWord3), .statusWord(statusWord),
    .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata), .memRdata(memRdata),
    .busy(busy), .done(done), .fixCount(fixCount), .fail(fail)
  );

  assign memRdata = (int'(memAddr) < MEM_N) ? mem[memAddr] : 8'h00;

  always @(posedge clk or posedge loadPulse) begin
    if (loadPulse) begin
      for (int i = 0; i < MEM_N; i++) mem[i] <= stageMem[i];
    end else if (memWe && int'(memAddr) < MEM_N) begin
      mem[memAddr] <= memWdata;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (memWe && (!busy || int'(memAddr) >= DATA_N)) badWrites++;
    if (cycles > 190000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic loadMem();
    loadPulse = 1'b1;
    #1;
    loadPulse = 1'b0;
    #1;
  endtask

  task automatic buildWords(input int cnt);
    logic [103:0] v;
    for (int k = 0; k < 8; k++) v[13*k +: 13] = slots[k];
    errWord1   = v[31:0];
    errWord2   = v[63:32];
    errWord3   = v[95:64];
    statusWord = {8'hA5, v[103:96], 2'b10, 4'(cnt), 10'h1B7};
  endtask

  task automatic predict();
    logic [103:0] v;
    int cnt, adj, zE, zD;
    v = {statusWord[23:16], errWord3, errWord2, errWord1};
    cnt = int'(statusWord[13:10]);
    for (int i = 0; i < MEM_N; i++) expMem[i] = mem[i];
    expCnt = 0;
    expFail = 1'b0;
    if (cnt >= 1 && cnt <= 8) begin
      for (int k = 0; k < cnt; k++) begin
        adj = int'(v[13*k +: 13] ^ 13'd3);
        if (adj < DATA_N * 8) begin
          expMem[adj / 8][adj % 8] = ~expMem[adj / 8][adj % 8];
          expCnt++;
        end
      end
    end else if (cnt > 8) begin
      zE = 0;
      zD = 0;
      for (int i = 0; i < ECC_N; i++) zE += $countones(~expMem[DATA_N + i]);
      for (int i = 0; i < DATA_N; i++) zD += $countones(~expMem[i]);
      if (zE + zD <= 8) begin
        for (int i = 0; i < DATA_N; i++) expMem[i] = 8'hFF;
      end else begin
        expFail = 1'b1;
      end
    end
  endtask

  task automatic compareMem(input string req);
    int bad, first;
    bad = 0;
    first = -1;
    for (int i = 0; i < MEM_N; i++) begin
      if (mem[i] !== expMem[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    end
    if (first < 0) chk(1'b1, req, "buffer", 0, 0);
    else chk(1'b0, req, $sformatf("buffer byte %0d", first), int'(mem[first]), int'(expMem[first]));
  endtask

  task automatic runJob(input int cnt, input string req);
    int waitN;
    buildWords(cnt);
    predict();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitN = 0;
    while (!done && waitN < 1500) begin
      @(negedge clk);
      waitN++;
    end
    if (!done) begin
      chk(1'b0, req, "done timeout", waitN, 1500);
    end else begin
      chk(int'(fixCount) == expCnt, req, "fixCount", int'(fixCount), expCnt);
      chk(fail == expFail, req, "fail", int'(fail), int'(expFail));
      compareMem(req);
    end
    @(negedge clk);
    chk(!done && !busy, "R8", "done/busy after job", int'({done, busy}), 0);
  endtask

  task automatic patternMem();
    for (int i = 0; i < DATA_N; i++) stageMem[i] = 8'((i * 29 + 7) & 255);
    for (int i = 0; i < ECC_N; i++) stageMem[DATA_N + i] = 8'((i * 53 + 1) & 255);
    loadMem();
  endtask

  task automatic erasedMem(input int eccZ, input int datZ);
    int b;
    for (int i = 0; i < MEM_N; i++) stageMem[i] = 8'hFF;
    for (int i = 0; i < eccZ; i++) begin
      b = (i * 5) % (ECC_N * 8);
      stageMem[DATA_N + b / 8][b % 8] = 1'b0;
    end
    for (int i = 0; i < datZ; i++) begin
      b = (i * 37 + 11) % (DATA_N * 8);
      stageMem[b / 8][b % 8] = 1'b0;
    end
    loadMem();
  endtask

  initial begin
    int doneSeen;
    // R10: reset state
    repeat (3) @(negedge clk);
    chk(!busy && !done && !memWe, "R10", "busy/done/memWe in reset", int'({busy, done, memWe}), 0);
    chk(fixCount == 4'd0 && !fail, "R10", "results in reset", int'({fixCount, fail}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R10", "idle after reset", int'({busy, done}), 0);

    patternMem();

    // R1: zero count, in-range locations present, noise in other status bits
    for (int k = 0; k < 8; k++) slots[k] = 13'(k * 100);
    runJob(0, "R1");

    // R3 R4: single location swept over every raw value
    for (int raw = 0; raw < 8192; raw++) begin
      slots[0] = 13'(raw);
      for (int k = 1; k < 8; k++) slots[k] = 13'(raw) ^ 13'h1555;
      runJob(1, (raw < 4096) ? "R3" : "R4");
    end

    // R2: each slot position carries the only live location, count 8
    for (int s = 0; s < 8; s++) begin
      for (int vi = 0; vi < 5; vi++) begin
        for (int k = 0; k < 8; k++) slots[k] = 13'h1000;
        case (vi)
          0: slots[s] = 13'h0000;
          1: slots[s] = 13'h0FFF;
          2: slots[s] = 13'h0ABC;
          3: slots[s] = 13'h0555;
          default: slots[s] = 13'h1AAA;
        endcase
        runJob(8, "R2");
      end
    end

    // R5: count limits how many slots apply
    for (int n = 1; n <= 8; n++) begin
      for (int k = 0; k < 8; k++) slots[k] = 13'((k * 517 + 3) & 12'hFFF);
      runJob(n, "R5");
    end
    // duplicate location flips twice
    for (int k = 0; k < 8; k++) slots[k] = 13'h0123;
    runJob(2, "R4");

    // R6 R7: erased-check grid across the limit
    for (int j = 0; j <= 10; j++) begin
      for (int d = 0; d <= 10; d++) begin
        erasedMem(j, d);
        for (int k = 0; k < 8; k++) slots[k] = 13'(j * 11 + d);
        runJob(9 + ((j + d) % 7), (j + d <= 8) ? "R6" : "R7");
      end
    end

    // R8: start during a job is ignored
    erasedMem(1, 2);
    for (int k = 0; k < 8; k++) slots[k] = 13'h0000;
    buildWords(12);
    predict();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    buildWords(1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    doneSeen = 0;
    for (int t = 0; t < 1500; t++) begin
      if (done) doneSeen++;
      if (doneSeen > 0 && !busy) break;
      @(negedge clk);
    end
    chk(doneSeen == 1, "R8", "done pulses for busy start", doneSeen, 1);
    chk(int'(fixCount) == 0 && !fail, "R8", "result of first job", int'({fixCount, fail}), 0);
    compareMem("R8");
    repeat (10) begin
      @(negedge clk);
      if (done || busy) doneSeen++;
    end
    chk(doneSeen == 1, "R8", "no job from ignored start", doneSeen, 1);

    chk(badWrites == 0, "R9", "writes outside data or idle", badWrites, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule